// File: doc/BRIEF.md
# Banked External Address Generator

This block forms the external memory address for an 8-bit controller core whose memory bus is kept apart from its general ports. For each bus cycle the core reports what kind of cycle it is running. The block then chooses the low and high address bytes from the program counter, the data pointer, or the page register paired with an 8-bit index register. It also drives a 4-bit upper field that is used in one of two ways.

Two special registers sit behind a small register port: a page register and a mode/bank register. In extended mode, the upper field carries the bank nibble on data and table cycles, which gives 20-bit data addressing. On instruction fetches the field is zero, so code always runs from the first 64K. In select mode, the same four pins become active-low device selects. The top two bits of the high address byte decode them, so each select covers one 16K quarter.

Top module: `xbank_addr_gen`

## Requirements
- R1: After reset the page register reads 00h, the mode/bank register reads 70h, and the upper field is 0 on a fetch cycle.
- R2: Bits 6..4 of the mode/bank register (address A2h) always read as 1, whatever value was written to them.
- R3: A write on the register port changes the register at the next rising clock edge. A read returns the addressed register combinationally.
- R4: Cycle code 00 (fetch) takes the high byte from pc[15:8] and the low byte from pc[7:0]. In extended mode (A2h bit 7 = 0) the upper field is 0.
- R5: Cycle code 01 (table read) takes the address bytes from dptr. In extended mode the upper field equals A2h bits 3..0.
- R6: Cycle code 10 (data access through the data pointer) takes the address bytes from dptr. In extended mode the upper field equals A2h bits 3..0.
- R7: Cycle code 11 (data access through an index register) takes the high byte from the page register (A1h) and the low byte from ri. In extended mode the upper field equals A2h bits 3..0.
- R8: In select mode (A2h bit 7 = 1), exactly one upper-field bit is low on every cycle. It is bit n, where n is the high address byte's bits 7..6 read as an unsigned value.
- R9: A write to any address other than A1h or A2h changes neither register. A read of any other address returns 00h.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 8 | Register port address |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data |
| cyc_kind | input | 2 | Cycle type code from the core |
| pc | input | 16 | Program counter |
| dptr | input | 16 | Data pointer or table effective address |
| ri | input | 8 | Index register value |
| addr_lo | output | 8 | Low address byte |
| addr_hi | output | 8 | High address byte |
| addr_up | output | 4 | Bank nibble or active-low selects |

## Verification
A corrupted page or bank register appears on the very next index-register or data cycle as a wrong high byte or wrong upper field. It also appears at once on a read of the register port. A corrupted mode bit appears within one cycle, either as a nonzero field on fetches or as a select pattern that is not one-hot. The bench sweeps every 16-bit fetch address in both modes. This exposes a decoder or fetch-gating fault on the first address that hits it.

// File: rtl/xbank_pkg.sv
package xbank_pkg;
  typedef enum logic [1:0] {
    CYC_FETCH = 2'b00,
    CYC_TABLE = 2'b01,
    CYC_XDPTR = 2'b10,
    CYC_XRI   = 2'b11
  } cyc_kind_e;
endpackage

// File: rtl/xbank_regs.sv
module xbank_regs #(
  parameter int DW = 8,
  parameter int NIB_W = 4,
  parameter logic [7:0] PAGE_ADDR = 8'hA1,
  parameter logic [7:0] MODE_ADDR = 8'hA2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [7:0]       reg_addr,
  input  logic             reg_wr,
  input  logic [DW-1:0]    reg_wdata,
  output logic [DW-1:0]    reg_rdata,
  output logic [DW-1:0]    page,
  output logic             cs_mode,
  output logic [NIB_W-1:0] bank
);
  localparam int RSV_W = DW - 1 - NIB_W;

  logic [DW-1:0]    page_q, page_d;
  logic             mode_q, mode_d;
  logic [NIB_W-1:0] bank_q, bank_d;
  logic             page_en, mode_en;

  assign page_en = reg_wr && (reg_addr == PAGE_ADDR);
  assign mode_en = reg_wr && (reg_addr == MODE_ADDR);

  always_comb begin
    page_d = page_q;
    mode_d = mode_q;
    bank_d = bank_q;
    if (page_en) page_d = reg_wdata;
    if (mode_en) begin
      mode_d = reg_wdata[DW-1];
      bank_d = reg_wdata[NIB_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      page_q <= '0;
      mode_q <= 1'b0;
      bank_q <= '0;
    end else begin
      page_q <= page_d;
      mode_q <= mode_d;
      bank_q <= bank_d;
    end
  end

  always_comb begin
    if (reg_addr == PAGE_ADDR)      reg_rdata = page_q;
    else if (reg_addr == MODE_ADDR) reg_rdata = {mode_q, {RSV_W{1'b1}}, bank_q};
    else                            reg_rdata = '0;
  end

  assign page    = page_q;
  assign cs_mode = mode_q;
  assign bank    = bank_q;
endmodule

// File: rtl/xbank_addr_mux.sv
module xbank_addr_mux
  import xbank_pkg::*;
#(
  parameter int DW = 8
) (
  input  cyc_kind_e       kind,
  input  logic [2*DW-1:0] pc,
  input  logic [2*DW-1:0] dptr,
  input  logic [DW-1:0]   ri,
  input  logic [DW-1:0]   page,
  output logic [DW-1:0]   hi,
  output logic [DW-1:0]   lo
);
  always_comb begin
    unique case (kind)
      CYC_FETCH: {hi, lo} = pc;
      CYC_TABLE,
      CYC_XDPTR: {hi, lo} = dptr;
      CYC_XRI:   {hi, lo} = {page, ri};
      default:   {hi, lo} = pc;
    endcase
  end
endmodule

// File: rtl/xbank_upper.sv
module xbank_upper
  import xbank_pkg::*;
#(
  parameter int DW = 8,
  parameter int NIB_W = 4
) (
  input  cyc_kind_e        kind,
  input  logic             cs_mode,
  input  logic [NIB_W-1:0] bank,
  input  logic [DW-1:0]    hi,
  output logic [NIB_W-1:0] up
);
  localparam int SEL_W = $clog2(NIB_W);

  logic [NIB_W-1:0] sel_n;
  logic [NIB_W-1:0] ext_val;
  logic [SEL_W-1:0] sel;

  assign sel = hi[DW-1 -: SEL_W];

  for (genvar g = 0; g < NIB_W; g++) begin : g_sel
    assign sel_n[g] = (sel != SEL_W'(g));
  end

  assign ext_val = (kind == CYC_FETCH) ? '0 : bank;
  assign up = cs_mode ? sel_n : ext_val;
endmodule

// File: rtl/xbank_addr_gen.sv
module xbank_addr_gen
  import xbank_pkg::*;
#(
  parameter int DW = 8,
  parameter int NIB_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [7:0]       reg_addr,
  input  logic             reg_wr,
  input  logic [DW-1:0]    reg_wdata,
  output logic [DW-1:0]    reg_rdata,
  input  logic [1:0]       cyc_kind,
  input  logic [2*DW-1:0]  pc,
  input  logic [2*DW-1:0]  dptr,
  input  logic [DW-1:0]    ri,
  output logic [DW-1:0]    addr_lo,
  output logic [DW-1:0]    addr_hi,
  output logic [NIB_W-1:0] addr_up
);
  logic [1:0]       rst_sync_q;
  logic             rst_sync_n;
  logic [DW-1:0]    pg_val;
  logic             cs_mode_w;
  logic [NIB_W-1:0] bank_w;
  cyc_kind_e        kind;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sync_n = rst_sync_q[1];

  assign kind = cyc_kind_e'(cyc_kind);

  xbank_regs #(.DW(DW), .NIB_W(NIB_W)) u_regs (
    .clk(clk), .rst_n(rst_sync_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .page(pg_val),
    .cs_mode(cs_mode_w), .bank(bank_w)
  );

  xbank_addr_mux #(.DW(DW)) u_mux (
    .kind(kind), .pc(pc), .dptr(dptr), .ri(ri), .page(pg_val),
    .hi(addr_hi), .lo(addr_lo)
  );

  xbank_upper #(.DW(DW), .NIB_W(NIB_W)) u_upper (
    .kind(kind), .cs_mode(cs_mode_w), .bank(bank_w), .hi(addr_hi), .up(addr_up)
  );
endmodule

// File: rtl/xbank_chk.sv
module xbank_chk #(
  parameter int DW = 8,
  parameter int NIB_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       cyc_kind,
  input logic [DW-1:0]    addr_hi,
  input logic [DW-1:0]    addr_lo,
  input logic [NIB_W-1:0] addr_up,
  input logic [DW-1:0]    ri,
  input logic [7:0]       reg_addr,
  input logic             reg_wr,
  input logic [DW-1:0]    reg_wdata,
  input logic [DW-1:0]    reg_rdata,
  input logic [DW-1:0]    page,
  input logic             cs_mode
);
  // R4
  fetch_up_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_mode && cyc_kind == 2'b00) |-> (addr_up == '0));

  // R8
  cs_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_mode |-> ($countones(~addr_up) == 1));

  // R2
  rsv_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == 8'hA2) |-> (reg_rdata[DW-2 -: 3] == 3'b111));

  // R3
  page_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 8'hA1) |=> (page == $past(reg_wdata)));

  // R7
  ri_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_kind == 2'b11) |-> (addr_hi == page && addr_lo == ri));
endmodule

bind xbank_addr_gen xbank_chk #(.DW(DW), .NIB_W(NIB_W)) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .cyc_kind(cyc_kind), .addr_hi(addr_hi),
  .addr_lo(addr_lo), .addr_up(addr_up), .ri(ri), .reg_addr(reg_addr),
  .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
  .page(pg_val), .cs_mode(cs_mode_w)
);

// File: tb/xbank_addr_gen_test.sv
module xbank_addr_gen_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  reg_addr = 8'h00;
  logic        reg_wr = 1'b0;
  logic [7:0]  reg_wdata = 8'h00;
  logic [7:0]  reg_rdata;
  logic [1:0]  cyc_kind = 2'b00;
  logic [15:0] pc = 16'h0;
  logic [15:0] dptr = 16'h0;
  logic [7:0]  ri = 8'h0;
  logic [7:0]  addr_lo, addr_hi;
  logic [3:0]  addr_up;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  xbank_addr_gen uut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cyc_kind(cyc_kind),
    .pc(pc), .dptr(dptr), .ri(ri), .addr_lo(addr_lo), .addr_hi(addr_hi),
    .addr_up(addr_up)
  );

  // {kind, pc, dptr, ri, exp_hi, exp_lo, exp_up}; page=3C, bank=5, extended mode
  localparam logic [77:0] VEC [8] = '{
    {2'b00, 16'h1234, 16'hABCD, 8'h77, 8'h12, 8'h34, 4'h0, 16'h0}, // R4
    {2'b01, 16'h1234, 16'hABCD, 8'h77, 8'hAB, 8'hCD, 4'h5, 16'h0}, // R5
    {2'b10, 16'h1234, 16'h00FF, 8'h77, 8'h00, 8'hFF, 4'h5, 16'h0}, // R6
    {2'b11, 16'h1234, 16'hABCD, 8'h77, 8'h3C, 8'h77, 4'h5, 16'h0}, // R7
    {2'b00, 16'hFFFF, 16'h0000, 8'h00, 8'hFF, 8'hFF, 4'h0, 16'h0}, // R4
    {2'b01, 16'hFFFF, 16'h0000, 8'h55, 8'h00, 8'h00, 4'h5, 16'h0}, // R5
    {2'b11, 16'h0000, 16'hFFFF, 8'h00, 8'h3C, 8'h00, 4'h5, 16'h0}, // R7
    {2'b10, 16'h0000, 16'hFFFF, 8'hAA, 8'hFF, 8'hFF, 4'h5, 16'h0}  // R6
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [7:0] a, input logic [7:0] exp);
    reg_addr = a;
    #1;
    check(req, {24'h0, reg_rdata}, {24'h0, exp});
  endtask

  initial begin
    #2000000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    rd_chk("R1 page reset", 8'hA1, 8'h00);
    rd_chk("R1 mode reset", 8'hA2, 8'h70);
    cyc_kind = 2'b01; #1;
    check("R1 up zero bank", {28'h0, addr_up}, 32'h0);

    // R3 timing: just before the edge the value is old, just after it is new
    @(negedge clk);
    reg_addr = 8'hA1; reg_wdata = 8'h3C; reg_wr = 1'b1;
    #1 check("R3 before edge", {24'h0, reg_rdata}, 32'h00);
    @(negedge clk);
    reg_wr = 1'b0;
    rd_chk("R3 after edge", 8'hA1, 8'h3C);

    // R2 reserved bits
    wr_reg(8'hA2, 8'h00);
    rd_chk("R2 zero write", 8'hA2, 8'h70);
    wr_reg(8'hA2, 8'h05);
    rd_chk("R2 bank write", 8'hA2, 8'h75);

    // R9 ignored writes and unmapped read
    wr_reg(8'hA3, 8'hFF);
    wr_reg(8'hA0, 8'hFF);
    rd_chk("R9 page kept", 8'hA1, 8'h3C);
    rd_chk("R9 mode kept", 8'hA2, 8'h75);
    rd_chk("R9 unmapped read", 8'hA6, 8'h00);

    // Vector table, extended mode (R4 R5 R6 R7)
    for (int i = 0; i < 8; i++) begin
      {cyc_kind, pc, dptr, ri} = VEC[i][77:36];
      #1;
      check("R4-7 vec hi", {24'h0, addr_hi}, {24'h0, VEC[i][35:28]});
      check("R4-7 vec lo", {24'h0, addr_lo}, {24'h0, VEC[i][27:20]});
      check("R4-7 vec up", {28'h0, addr_up}, {28'h0, VEC[i][19:16]});
    end

    // R4 all fetch addresses give zero nibble with bank=F
    wr_reg(8'hA2, 8'h0F);
    cyc_kind = 2'b00;
    for (int a = 0; a < 65536; a++) begin
      pc = 16'(a); #1;
      check("R4 fetch sweep", {28'h0, addr_up}, 32'h0);
    end
    cyc_kind = 2'b10; dptr = 16'h8001; #1;
    check("R6 bank F", {28'h0, addr_up}, 32'hF);

    // R8 select mode
    wr_reg(8'hA2, 8'h85);
    rd_chk("R8 mode readback", 8'hA2, 8'hF5);
    cyc_kind = 2'b00;
    for (int a = 0; a < 65536; a++) begin
      pc = 16'(a); #1;
      check("R8 select sweep", {28'h0, addr_up}, {28'h0, ~(4'b0001 << pc[15:14])});
    end
    wr_reg(8'hA1, 8'hC0);
    cyc_kind = 2'b11; ri = 8'h12; #1;
    check("R8 select via page", {28'h0, addr_up}, 32'h7);
    cyc_kind = 2'b01; dptr = 16'h4000; #1;
    check("R8 select table", {28'h0, addr_up}, 32'hD);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule